// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block collects 64 level-sensitive interrupt request lines and reports the single most urgent one to the processor core. It reports that source as a priority level and a vector number. Each source has its own 8-bit level register. A nonzero level both enables the source and sets its urgency. A 64-bit mask blocks individual sources. A 64-bit force word also takes part in the selection, but it has no write path and always reads zero.

Software reaches the state through a small synchronous register bus. The bus has an 8-bit byte address, 32-bit write data and one-cycle registered read data. It covers the pending and mask words, the per-source level bytes and two byte-wide ports that set or clear one mask bit or all of them. An acknowledge location returns the vector that is currently presented.

The level and vector outputs are registered. They are recomputed on every clock from the present state.

Top module: `prio_intc`

## Requirements
- R1: A source is active when (pending | force) & enabled & ~mask is 1 for it. When no source is active, cpu_level reads 0 on the following cycle.
- R2: A write to byte address 0x40+n (n = 0..63) stores bus_wdata[7:0] as the level of source n. Writing 0 disables source n and any nonzero value enables it. A read at 0x40+n returns the level in bits [7:0] and zero above.
- R3: Among the active sources, the one with the largest level wins. When levels are equal, the source with the larger index wins.
- R4: While a source is active, cpu_level equals the winner's level and cpu_vector equals 64 + winner index.
- R5: While no source is active, cpu_level is 0 and cpu_vector is 24.
- R6: The pending bit of each source copies irq_req on every clock. Writes to 0x00 and 0x04 are ignored. A read at 0x00 returns pending[63:32] and a read at 0x04 returns pending[31:0].
- R7: The mask can be read and written as two 32-bit words: 0x08 holds mask[63:32] and 0x0C holds mask[31:0]. A mask bit of 1 blocks its source.
- R8: A write to 0x1C with bus_wdata[6]=0 sets the mask bit selected by bus_wdata[5:0]. With bus_wdata[6]=1 it sets all 64 mask bits.
- R9: A write to 0x1D with bus_wdata[6]=0 clears the mask bit selected by bus_wdata[5:0]. With bus_wdata[6]=1 it clears all 64 mask bits.
- R10: A read at 0xE0 returns the presented vector in bits [7:0]. Reads at 0xE1 to 0xE7 and at unmapped addresses return 0. Writes to unmapped addresses change no state.
- R11: Reads of the force words at 0x10 (upper) and 0x14 (lower) return 0.
- R12: After reset, all mask bits are 1, pending, enables and levels are 0, cpu_level is 0 and cpu_vector is 24.
- R13: A register write taken at clock edge k shows at the outputs after edge k+1, and an irq_req change shows after two edges. bus_rdata is valid after the edge that samples bus_rd and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 64 | Level-sensitive request lines, one per source |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data; byte registers use bits [7:0] |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| cpu_level | output | 8 | Level of the winning source, 0 when none |
| cpu_vector | output | 8 | 64 + winning index, or 24 when none |

## Verification
The selection is first tried with single sources, each gated in turn by enable, mask and pending, so that each term of the active equation is seen to matter on its own. Two sources at equal level, then at unequal levels, separate the index tie-break from the level comparison. A run of pseudo-random request, level and mask patterns uses levels from a range of 0 to 3, so that ties and disabled sources are frequent. Across these patterns the outputs are compared with a model that scans downward with a strict comparison. Mask byte ports, ignored pending writes, unmapped accesses and the acknowledge read are checked through read-back and the outputs.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC = 64;
  localparam int LVLW = 8;
  localparam int VECW = 8;
  localparam int DATW = 32;
  localparam int ADRW = 8;
  localparam int IDXW = $clog2(NSRC);
  localparam int HALF = NSRC / 2;
  localparam int ALLB = IDXW;  // data bit that selects "all mask bits"

  localparam logic [VECW-1:0] VEC_NONE = VECW'(24);
  localparam logic [VECW-1:0] VEC_BASE = VECW'(64);

  localparam logic [ADRW-1:0] A_PEND_HI = 8'h00;
  localparam logic [ADRW-1:0] A_PEND_LO = 8'h04;
  localparam logic [ADRW-1:0] A_MASK_HI = 8'h08;
  localparam logic [ADRW-1:0] A_MASK_LO = 8'h0C;
  localparam logic [ADRW-1:0] A_FRC_HI  = 8'h10;
  localparam logic [ADRW-1:0] A_FRC_LO  = 8'h14;
  localparam logic [ADRW-1:0] A_MSET    = 8'h1C;
  localparam logic [ADRW-1:0] A_MCLR    = 8'h1D;
  localparam logic [ADRW-1:0] A_LVL     = 8'h40;
  localparam logic [ADRW-1:0] A_ACK     = 8'hE0;

  typedef struct packed {
    logic            hit;
    logic [IDXW-1:0] idx;
    logic [LVLW-1:0] lvl;
  } pick_t;

  // upward scan, >= keeps the later (higher) index on a tie
  function automatic pick_t pick_winner(input logic [NSRC-1:0] act,
                                        input logic [NSRC-1:0][LVLW-1:0] lv);
    pick_t r;
    r = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (act[i] && lv[i] >= r.lvl) begin
        r.hit = 1'b1;
        r.idx = IDXW'(i);
        r.lvl = lv[i];
      end
    end
    return r;
  endfunction

  function automatic logic [VECW-1:0] vec_of(input pick_t p);
    return p.hit ? VEC_BASE + VECW'(p.idx) : VEC_NONE;
  endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             irq_req,
  input  logic [ADRW-1:0]             bus_addr,
  input  logic [DATW-1:0]             bus_wdata,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [VECW-1:0]             ack_vec,
  output logic [DATW-1:0]             bus_rdata,
  output logic [NSRC-1:0]             active,
  output logic [NSRC-1:0][LVLW-1:0]   levels
);
  logic [NSRC-1:0]           pend_q, mask_q, en_q, mask_d;
  logic [NSRC-1:0][LVLW-1:0] lvl_q;
  logic [NSRC-1:0]           force_w;
  logic [DATW-1:0]           rd_d;

  // force has no write path: held at its reset value
  assign force_w = '0;

  // decoded bus events
  logic            in_lvl, lvl_wr, mhi_wr, mlo_wr, mset_wr, mclr_wr;
  logic [IDXW-1:0] lvl_idx, bit_idx;
  assign in_lvl  = int'(bus_addr) >= int'(A_LVL) && int'(bus_addr) < int'(A_LVL) + NSRC;
  assign lvl_idx = IDXW'(bus_addr - A_LVL);
  assign bit_idx = bus_wdata[IDXW-1:0];
  assign lvl_wr  = bus_wr && in_lvl;
  assign mhi_wr  = bus_wr && bus_addr == A_MASK_HI;
  assign mlo_wr  = bus_wr && bus_addr == A_MASK_LO;
  assign mset_wr = bus_wr && bus_addr == A_MSET;
  assign mclr_wr = bus_wr && bus_addr == A_MCLR;

  always_comb begin
    mask_d = mask_q;
    if (mhi_wr) mask_d[NSRC-1:HALF] = bus_wdata;
    if (mlo_wr) mask_d[HALF-1:0]    = bus_wdata;
    if (mset_wr) begin
      if (bus_wdata[ALLB]) mask_d = '1;
      else                 mask_d[bit_idx] = 1'b1;
    end
    if (mclr_wr) begin
      if (bus_wdata[ALLB]) mask_d = '0;
      else                 mask_d[bit_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
      en_q   <= '0;
      lvl_q  <= '0;
    end else begin
      pend_q <= irq_req;
      mask_q <= mask_d;
      if (lvl_wr) begin
        lvl_q[lvl_idx] <= bus_wdata[LVLW-1:0];
        en_q[lvl_idx]  <= |bus_wdata[LVLW-1:0];
      end
    end
  end

  always_comb begin
    rd_d = '0;
    if (in_lvl) rd_d = DATW'(lvl_q[lvl_idx]);
    else begin
      case (bus_addr)
        A_PEND_HI: rd_d = pend_q[NSRC-1:HALF];
        A_PEND_LO: rd_d = pend_q[HALF-1:0];
        A_MASK_HI: rd_d = mask_q[NSRC-1:HALF];
        A_MASK_LO: rd_d = mask_q[HALF-1:0];
        A_FRC_HI:  rd_d = force_w[NSRC-1:HALF];
        A_FRC_LO:  rd_d = force_w[HALF-1:0];
        A_ACK:     rd_d = DATW'(ack_vec);
        default:   rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_d;
  end

  assign active = (pend_q | force_w) & en_q & ~mask_q;
  assign levels = lvl_q;

  // R6
  pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend_q == $past(irq_req));
  // R2
  lvl_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_wr |=> en_q[$past(lvl_idx)] == (|$past(bus_wdata[LVLW-1:0])));
  // R8
  mask_setall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mset_wr && bus_wdata[ALLB] |=> &mask_q);
  // R9
  mask_clrall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_wr && bus_wdata[ALLB] |=> mask_q == '0);
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
(
  input  logic [NSRC-1:0]           active,
  input  logic [NSRC-1:0][LVLW-1:0] levels,
  output pick_t                     win
);
  assign win = pick_winner(active, levels);
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      irq_req,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic [31:0]      bus_rdata,
  output logic [7:0]       cpu_level,
  output logic [7:0]       cpu_vector
);
  logic [NSRC-1:0]           active;
  logic [NSRC-1:0][LVLW-1:0] levels;
  pick_t                     win;

  intc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .ack_vec(cpu_vector), .bus_rdata(bus_rdata),
    .active(active), .levels(levels)
  );

  intc_arb u_arb (.active(active), .levels(levels), .win(win));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_level  <= '0;
      cpu_vector <= VEC_NONE;
    end else begin
      cpu_level  <= win.lvl;
      cpu_vector <= vec_of(win);
    end
  end

  // R5
  spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_level == '0 |-> cpu_vector == VEC_NONE);
  // R4
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_level != '0 |-> cpu_vector >= VEC_BASE);
  // R3
  win_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win.hit |-> active[win.idx]);
  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active == '0 |=> cpu_level == '0);
endmodule

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_req = '0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  cpu_level, cpu_vector;

  prio_intc u0 (.*);

  always #4 clk = ~clk;  // 125 MHz

  typedef struct {
    int          kind;  // 0: {level,vector}, 1: read data
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sbq[$];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench-side mirror
  logic [63:0] irq_m = '0;
  logic [63:0] mask_m = '1;
  int          lvl_m[64];

  // downward scan with strict compare: first seen (highest index) keeps ties
  function automatic logic [31:0] model_out();
    int best = -1;
    int bl = 0;
    for (int i = 63; i >= 0; i--)
      if (irq_m[i] && !mask_m[i] && lvl_m[i] > bl) begin bl = lvl_m[i]; best = i; end
    if (best < 0) return {16'd0, 8'd0, 8'd24};
    return {16'd0, 8'(bl), 8'(64 + best)};
  endfunction

  // monitor
  initial forever begin
    @(negedge clk); #1;
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      act = (it.kind == 0) ? {16'd0, cpu_level, cpu_vector} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    sbq.push_back('{1, e, req});
  endtask

  task automatic expect_out(input string req);
    @(negedge clk);
    sbq.push_back('{0, model_out(), req});
  endtask

  task automatic put_level(input int n, input int v);
    wr(8'(8'h40 + n), 32'(v)); lvl_m[n] = v;
  endtask

  task automatic mset(input logic [7:0] d);
    wr(8'h1C, {24'd0, d});
    if (d[6]) mask_m = '1; else mask_m[d[5:0]] = 1'b1;
  endtask

  task automatic mclr(input logic [7:0] d);
    wr(8'h1D, {24'd0, d});
    if (d[6]) mask_m = '0; else mask_m[d[5:0]] = 1'b0;
  endtask

  task automatic set_irq(input logic [63:0] v);
    irq_req = v; irq_m = v;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] lfsr;
    for (int i = 0; i < 64; i++) lvl_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    sbq.push_back('{0, {16'd0, 8'd0, 8'd24}, "R12"});
    rd(8'h08, 32'hFFFF_FFFF, "R12 mask hi");
    rd(8'h0C, 32'hFFFF_FFFF, "R12 mask lo");
    rd(8'h04, 32'h0, "R12 pending");
    rd(8'h47, 32'h0, "R12 level");

    // R1: pending alone, then enable, then unmask
    set_irq(64'h20);
    expect_out("R1 not enabled");
    put_level(5, 3);
    expect_out("R1 masked");
    rd(8'h45, 32'h3, "R2 level readback");
    mclr(8'd5);
    expect_out("R4 single source");
    rd(8'hE0, 32'd69, "R10 ack vector");
    rd(8'h04, 32'h20, "R6 pending lo");

    // R3 tie goes to higher index
    set_irq(64'h0000_0100_0000_0020);
    put_level(40, 3);
    mclr(8'd40);
    expect_out("R3 tie");
    rd(8'h00, 32'h100, "R6 pending hi");
    put_level(5, 4);
    expect_out("R3 higher level");
    // R2 zero disables
    put_level(5, 0);
    expect_out("R2 zero disables");
    rd(8'h45, 32'h0, "R2 zero readback");

    // R6 pending writes ignored
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h04, 32'h20, "R6 write ignored lo");
    rd(8'h00, 32'h100, "R6 write ignored hi");

    // R8 set single mask bit
    mset(8'd40);
    expect_out("R8 set single");
    rd(8'h08, mask_m[63:32], "R8 mask hi");
    // R7 word writes
    wr(8'h0C, 32'h1234_5678); mask_m[31:0] = 32'h1234_5678;
    wr(8'h08, 32'h0); mask_m[63:32] = 32'h0;
    rd(8'h0C, 32'h1234_5678, "R7 mask lo");
    rd(8'h08, 32'h0, "R7 mask hi");
    expect_out("R7 unmask by word");
    // R8 / R9 all
    mset(8'h40);
    expect_out("R8 set all");
    rd(8'h0C, 32'hFFFF_FFFF, "R8 all lo");
    mclr(8'h40);
    rd(8'h08, 32'h0, "R9 clear all hi");
    rd(8'h0C, 32'h0, "R9 clear all lo");
    expect_out("R9 after clear all");
    mset(8'd40);
    mclr(8'd40);
    expect_out("R9 clear single");

    // R10 / R11 unmapped, lower acks, force
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    expect_out("R10 unmapped write");
    rd(8'h0C, 32'h0, "R10 mask untouched");
    rd(8'hE3, 32'h0, "R10 level ack reads zero");
    rd(8'h30, 32'h0, "R10 unmapped read");
    rd(8'hE0, 32'd104, "R10 ack vector");
    rd(8'h10, 32'h0, "R11 force hi");
    rd(8'h14, 32'h0, "R11 force lo");

    // R13: outputs lag a request drop by two edges
    irq_req = '0; irq_m = '0;
    @(negedge clk);
    sbq.push_back('{0, {16'd0, 8'd3, 8'd104}, "R13 one edge after drop"});
    expect_out("R5 none active");

    // pseudo-random patterns
    lfsr = 64'hACE1_2468_0F0F_1357;
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      put_level(int'(lfsr[5:0]), int'(lfsr[9:8]));
      put_level(int'(lfsr[21:16]), int'(lfsr[25:24]));
      wr(8'h0C, lfsr[47:16] | lfsr[31:0]); mask_m[31:0] = lfsr[47:16] | lfsr[31:0];
      wr(8'h08, lfsr[63:32] & lfsr[40:9]); mask_m[63:32] = lfsr[63:32] & lfsr[40:9];
      set_irq(lfsr ^ {lfsr[31:0], lfsr[63:32]});
      expect_out("R3 random pattern");
      rd(8'hE0, {24'd0, model_out()[7:0]}, "R10 random ack");
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule